// File: doc/BRIEF.md
# Cache Way Power-Gating Controller

This controller decides how many ways of a shared second-level cache stay powered while a two-core package enters and leaves deep sleep. Each accepted sleep-entry event can switch off a configurable number of ways. A way may only be switched off when several things hold together: the other core is parked, the deepest state is enabled, the awake-residency timer is still running, and the bus-to-core clock ratio is low enough. When the ratio is high, or when shallow activity appears, the controller brings ways back. It does this in two ways: on a wake it restores a minimum of two ways, and on the next interrupt it restores the whole cache.

Ways are always enabled from index 0 upward, so an enabled count of `c` means that ways 0 to c-1 are live. Ways that are being turned off go out as one flush request. Ways that are being turned back on go out as one invalidate request. Each request is a valid/ready handshake and is held until it is acknowledged. The controller also raises a permission output that tells the package it may enter its deepest state.

Top module: `wayGateCtl`

## Requirements
- R1: After reset the enabled count equals NUM_WAYS. Both requests and expandReq are low, and the residency timer is zero.
- R2: An accepted sleep entry under the shrink condition lowers the count by shrinkStep and saturates at 0. It raises flushValid with flushMask covering exactly the ways from the new count up to the old count minus one. No request is made when the count does not change.
- R3: The shrink condition needs all of the following: otherCoreC4 high, deepEnable high, the timer not expired, and the ratio not above the threshold. If any one of them fails, an accepted sleep entry leaves the count unchanged.
- R4: A busRatio of 0 is treated as below the threshold. A busRatio equal to shrinkThresh (and nonzero) allows no shrink and raises no expandReq.
- R5: An accepted sleep entry while busRatio is nonzero and above shrinkThresh does not shrink. Instead expandReq is high for exactly the following cycle.
- R6: The residency timer counts each cycle while the package is awake, and it saturates. An accepted sleep entry clears it, and the package then counts as asleep until an accepted wake. The timer is expired when its value is at least timerLimit.
- R7: An accepted wake event with a count below 2 sets the count to 2. It raises invValid with invMask covering the ways newly enabled.
- R8: After a wake has restored ways in that way, the next shrinking sleep entry sets the count straight to 0.
- R9: A pending full expand is latched in any cycle where the ratio is above the threshold, the timer is expired, or otherShallowReq is high. The next accepted interrupt then sets the count to NUM_WAYS, invalidates the restored ways and clears the pending flag.
- R10: An accepted shrinking sleep entry with sleepHint equal to 4'h2 sets the count to 0 in one step.
- R11: With shrinkPrevent high, an accepted sleep entry restores the count to NUM_WAYS, and deepAllowed stays low.
- R12: Only one request is ever outstanding. Each request holds its mask until ready is seen. Events that arrive while a request is outstanding are dropped. When events arrive together, sleep entry wins over wake, and wake wins over interrupt.
- R13: deepAllowed is high exactly when deepEnable is high, shrinkPrevent is low, the count is 0 and no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepEntry | input | 1 | Package deep-sleep entry event (pulse) |
| sleepHint | input | 4 | Sleep request hint; 4'h2 requests a full shrink |
| wakeEvent | input | 1 | Stop-clock release, first core waking (pulse) |
| irqEvent | input | 1 | Interrupt event (pulse) |
| otherCoreC4 | input | 1 | Other core already parked in C4 |
| otherShallowReq | input | 1 | Other core requests C1, C2 or C3 |
| deepEnable | input | 1 | Deepest power-down state enabled |
| shrinkPrevent | input | 1 | Keep the cache full and block the deepest states |
| busRatio | input | RATIO_W | Bus-to-core clock ratio; 0 means ignore |
| shrinkThresh | input | RATIO_W | Ratio threshold for shrinking |
| shrinkStep | input | WAY_W | Ways removed per sleep entry |
| timerLimit | input | TIMER_W | Awake-residency limit in cycles |
| flushReady | input | 1 | Flush engine accepts the request |
| invReady | input | 1 | Invalidate engine accepts the request |
| enabledWays | output | WAY_W | Current enabled-way count |
| flushValid | output | 1 | Flush request outstanding |
| flushMask | output | NUM_WAYS | Ways to flush |
| invValid | output | 1 | Invalidate request outstanding |
| invMask | output | NUM_WAYS | Ways to invalidate |
| expandReq | output | 1 | One-cycle cache expansion request |
| deepAllowed | output | 1 | Package may enter its deepest state |

## Verification
The interesting overlap is between a sleep, wake or interrupt event and a handshake that is still outstanding or finishing in the same cycle. The event must be dropped, even in the cycle where ready completes the request. The bench provokes this by holding ready low over several cycles and pulsing events into that window. It also provokes it with random ready and random event streams, and with sleep and interrupt pulsed together. Each outcome is judged by a bench model of the requirements, which predicts the count, the masks and the permission output every cycle.

// File: rtl/wgcPkg.sv
package wgcPkg;
  typedef struct packed {
    logic load;      // commit a new way count
    logic clrTimer;  // clear residency timer
    logic timerRun;  // package awake, timer counts
  } wgcStrobe_t;

  localparam logic [3:0] HINT_FULL = 4'h2;
endpackage

// File: rtl/wgcDatapath.sv
module wgcDatapath
  import wgcPkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int TIMER_W  = 16,
  parameter int WAY_W    = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  wgcStrobe_t          strobe,
  input  logic [WAY_W-1:0]    target,
  input  logic [TIMER_W-1:0]  timerLimit,
  input  logic                flushReady,
  input  logic                invReady,
  output logic [WAY_W-1:0]    wayCnt,
  output logic                timerExpired,
  output logic                reqIdle,
  output logic                flushValid,
  output logic [NUM_WAYS-1:0] flushMask,
  output logic                invValid,
  output logic [NUM_WAYS-1:0] invMask
);
  localparam logic [WAY_W-1:0] FULL = WAY_W'(NUM_WAYS);

  logic [TIMER_W-1:0]  timerVal;
  logic [NUM_WAYS-1:0] curMask, newMask;

  for (genvar i = 0; i < NUM_WAYS; i++) begin : gMask
    assign curMask[i] = (WAY_W'(i) < wayCnt);
    assign newMask[i] = (WAY_W'(i) < target);
  end

  assign timerExpired = (timerVal >= timerLimit);
  assign reqIdle      = !flushValid && !invValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerVal <= '0;
    end else if (strobe.clrTimer) begin
      timerVal <= '0;
    end else if (strobe.timerRun && timerVal != '1) begin
      timerVal <= timerVal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wayCnt     <= FULL;
      flushValid <= 1'b0;
      flushMask  <= '0;
      invValid   <= 1'b0;
      invMask    <= '0;
    end else begin
      if (flushValid && flushReady) flushValid <= 1'b0;
      if (invValid && invReady)     invValid   <= 1'b0;
      if (strobe.load) begin
        wayCnt <= target;
        if (target < wayCnt) begin
          flushValid <= 1'b1;
          flushMask  <= curMask & ~newMask;
        end else begin
          invValid <= 1'b1;
          invMask  <= newMask & ~curMask;
        end
      end
    end
  end

  a_r12_one_req: assert property (@(posedge clk) disable iff (!rstN)
    !(flushValid && invValid));
  a_r12_flush_hold: assert property (@(posedge clk) disable iff (!rstN)
    flushValid && !flushReady |=> flushValid && $stable(flushMask));
  a_r12_inv_hold: assert property (@(posedge clk) disable iff (!rstN)
    invValid && !invReady |=> invValid && $stable(invMask));
  a_r12_busy_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !reqIdle |=> $stable(wayCnt));
  a_r2_flush_outside: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> (flushMask & curMask) == '0);
  a_r7_inv_inside: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (invMask & ~curMask) == '0);
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    wayCnt <= FULL);
endmodule

// File: rtl/wgcControl.sv
module wgcControl
  import wgcPkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int RATIO_W  = 8,
  parameter int WAY_W    = $clog2(NUM_WAYS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepEntry,
  input  logic [3:0]         sleepHint,
  input  logic               wakeEvent,
  input  logic               irqEvent,
  input  logic               otherCoreC4,
  input  logic               otherShallowReq,
  input  logic               deepEnable,
  input  logic               shrinkPrevent,
  input  logic [RATIO_W-1:0] busRatio,
  input  logic [RATIO_W-1:0] shrinkThresh,
  input  logic [WAY_W-1:0]   shrinkStep,
  input  logic [WAY_W-1:0]   wayCnt,
  input  logic               timerExpired,
  input  logic               reqIdle,
  output wgcStrobe_t         strobe,
  output logic [WAY_W-1:0]   target,
  output logic               expandReq,
  output logic               deepAllowed
);
  localparam logic [WAY_W-1:0] FULL     = WAY_W'(NUM_WAYS);
  localparam int               WAKE_INT = (NUM_WAYS < 2) ? NUM_WAYS : 2;
  localparam logic [WAY_W-1:0] WAKE_CNT = WAY_W'(WAKE_INT);

  logic asleep, partial, pendFull;
  logic sleepTake, wakeTake, irqTake;
  logic ratioHigh, ratioLow, shrinkOk, expandNow;

  assign sleepTake = sleepEntry && reqIdle;
  assign wakeTake  = wakeEvent && reqIdle && !sleepEntry;
  assign irqTake   = irqEvent && reqIdle && !sleepEntry && !wakeEvent;

  assign ratioHigh = (busRatio != '0) && (busRatio > shrinkThresh);
  assign ratioLow  = (busRatio == '0) || (busRatio < shrinkThresh);
  assign shrinkOk  = otherCoreC4 && deepEnable && !timerExpired && ratioLow;

  always_comb begin
    target    = wayCnt;
    expandNow = 1'b0;
    if (sleepTake) begin
      if (shrinkPrevent)      target = FULL;
      else if (ratioHigh)     expandNow = 1'b1;
      else if (shrinkOk) begin
        if (sleepHint == HINT_FULL || partial) target = '0;
        else if (wayCnt > shrinkStep)          target = wayCnt - shrinkStep;
        else                                   target = '0;
      end
    end else if (wakeTake) begin
      if (wayCnt < WAKE_CNT) target = WAKE_CNT;
    end else if (irqTake) begin
      if (pendFull) target = FULL;
    end
  end

  assign strobe.load     = (sleepTake || wakeTake || irqTake) && (target != wayCnt);
  assign strobe.clrTimer = sleepTake;
  assign strobe.timerRun = !asleep;
  assign deepAllowed     = deepEnable && !shrinkPrevent && (wayCnt == '0) && reqIdle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asleep    <= 1'b0;
      partial   <= 1'b0;
      pendFull  <= 1'b0;
      expandReq <= 1'b0;
    end else begin
      expandReq <= expandNow;
      if (sleepTake)     asleep <= 1'b1;
      else if (wakeTake) asleep <= 1'b0;
      if (strobe.load) partial <= wakeTake;
      pendFull <= (pendFull && !irqTake) || ratioHigh || timerExpired || otherShallowReq;
    end
  end

  a_r5_expand_cause: assert property (@(posedge clk) disable iff (!rstN)
    expandReq |-> $past(sleepEntry));
  a_r12_drop_busy: assert property (@(posedge clk) disable iff (!rstN)
    !reqIdle |-> !strobe.load);
endmodule

// File: rtl/wayGateCtl.sv
module wayGateCtl
  import wgcPkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int RATIO_W  = 8,
  parameter int TIMER_W  = 16,
  parameter int WAY_W    = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepEntry,
  input  logic [3:0]          sleepHint,
  input  logic                wakeEvent,
  input  logic                irqEvent,
  input  logic                otherCoreC4,
  input  logic                otherShallowReq,
  input  logic                deepEnable,
  input  logic                shrinkPrevent,
  input  logic [RATIO_W-1:0]  busRatio,
  input  logic [RATIO_W-1:0]  shrinkThresh,
  input  logic [WAY_W-1:0]    shrinkStep,
  input  logic [TIMER_W-1:0]  timerLimit,
  input  logic                flushReady,
  input  logic                invReady,
  output logic [WAY_W-1:0]    enabledWays,
  output logic                flushValid,
  output logic [NUM_WAYS-1:0] flushMask,
  output logic                invValid,
  output logic [NUM_WAYS-1:0] invMask,
  output logic                expandReq,
  output logic                deepAllowed
);
  wgcStrobe_t       strobe;
  logic [WAY_W-1:0] target;
  logic             timerExpired, reqIdle;

  wgcControl #(.NUM_WAYS(NUM_WAYS), .RATIO_W(RATIO_W), .WAY_W(WAY_W)) uCtl (
    .clk(clk), .rstN(rstN), .sleepEntry(sleepEntry), .sleepHint(sleepHint),
    .wakeEvent(wakeEvent), .irqEvent(irqEvent), .otherCoreC4(otherCoreC4),
    .otherShallowReq(otherShallowReq), .deepEnable(deepEnable),
    .shrinkPrevent(shrinkPrevent), .busRatio(busRatio), .shrinkThresh(shrinkThresh),
    .shrinkStep(shrinkStep), .wayCnt(enabledWays), .timerExpired(timerExpired),
    .reqIdle(reqIdle), .strobe(strobe), .target(target), .expandReq(expandReq),
    .deepAllowed(deepAllowed)
  );

  wgcDatapath #(.NUM_WAYS(NUM_WAYS), .TIMER_W(TIMER_W), .WAY_W(WAY_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .target(target),
    .timerLimit(timerLimit), .flushReady(flushReady), .invReady(invReady),
    .wayCnt(enabledWays), .timerExpired(timerExpired), .reqIdle(reqIdle),
    .flushValid(flushValid), .flushMask(flushMask), .invValid(invValid),
    .invMask(invMask)
  );

  a_r13_deep_empty: assert property (@(posedge clk) disable iff (!rstN)
    deepAllowed |-> enabledWays == '0 && !flushValid && !invValid);
  a_r11_prevent_full: assert property (@(posedge clk) disable iff (!rstN)
    shrinkPrevent && $past(shrinkPrevent) && $past(sleepEntry) && $past(!flushValid && !invValid)
      |-> enabledWays == WAY_W'(NUM_WAYS));
endmodule

// File: tb/sim_wayGateCtl.sv
module sim_wayGateCtl;
  localparam int N  = 8;
  localparam int RW = 8;
  localparam int TW = 16;
  localparam int WW = $clog2(N + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic sleepEntry = 0, wakeEvent = 0, irqEvent = 0;
  logic [3:0] sleepHint = 0;
  logic otherCoreC4 = 1, otherShallowReq = 0, deepEnable = 1, shrinkPrevent = 0;
  logic [RW-1:0] busRatio = 5, shrinkThresh = 10;
  logic [WW-1:0] shrinkStep = 3;
  logic [TW-1:0] timerLimit = 1000;
  logic flushReady = 1, invReady = 1;
  logic [WW-1:0] enabledWays;
  logic flushValid, invValid, expandReq, deepAllowed;
  logic [N-1:0] flushMask, invMask;

  wayGateCtl #(.NUM_WAYS(N), .RATIO_W(RW), .TIMER_W(TW)) u0 (.*);

  always #2 clk = ~clk;

  int testsRun = 0, testsFailed = 0;
  string curTag = "R1";

  // bench model state
  int mCnt, mTimer;
  logic mFlV, mInV, mExp, mAsleep, mPartial, mPend;
  logic [N-1:0] mFlM, mInM;

  function automatic logic [N-1:0] waysBelow(int c);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) if (i < c) m[i] = 1'b1;
    return m;
  endfunction

  task automatic modelReset();
    mCnt = N; mTimer = 0; mFlV = 0; mInV = 0; mExp = 0;
    mAsleep = 0; mPartial = 0; mPend = 0; mFlM = '0; mInM = '0;
  endtask

  task automatic modelStep();
    logic idle, sTake, wTake, iTake, hi, lo, expired, ok;
    int tgt;
    idle  = !mFlV && !mInV;
    sTake = sleepEntry && idle;
    wTake = wakeEvent && idle && !sleepEntry;
    iTake = irqEvent && idle && !sleepEntry && !wakeEvent;
    hi = (busRatio != 0) && (busRatio > shrinkThresh);
    lo = (busRatio == 0) || (busRatio < shrinkThresh);
    expired = (mTimer >= int'(timerLimit));
    ok = otherCoreC4 && deepEnable && !expired && lo;
    tgt = mCnt;
    mExp = 0;
    if (sTake) begin
      if (shrinkPrevent) tgt = N;
      else if (hi) mExp = 1;
      else if (ok) tgt = (sleepHint == 4'h2 || mPartial) ? 0 :
                         (mCnt > int'(shrinkStep) ? mCnt - int'(shrinkStep) : 0);
    end else if (wTake) begin
      if (mCnt < 2) tgt = 2;
    end else if (iTake && mPend) tgt = N;
    if (mFlV && flushReady) mFlV = 0;
    if (mInV && invReady) mInV = 0;
    if (tgt != mCnt) begin
      if (tgt < mCnt) begin mFlV = 1; mFlM = waysBelow(mCnt) & ~waysBelow(tgt); end
      else begin mInV = 1; mInM = waysBelow(tgt) & ~waysBelow(mCnt); end
      mPartial = wTake;
      mCnt = tgt;
    end
    mPend = (mPend && !iTake) || hi || expired || otherShallowReq;
    if (sTake) mTimer = 0;
    else if (!mAsleep && mTimer < 65535) mTimer++;
    if (sTake) mAsleep = 1; else if (wTake) mAsleep = 0;
  endtask

  task automatic compare();
    logic expDeep;
    expDeep = deepEnable && !shrinkPrevent && mCnt == 0 && !mFlV && !mInV;
    testsRun++;
    if (int'(enabledWays) != mCnt || flushValid != mFlV || invValid != mInV ||
        (mFlV && flushMask != mFlM) || (mInV && invMask != mInM) ||
        expandReq != mExp || deepAllowed != expDeep) begin
      testsFailed++;
      $display("FAIL %s: ways=%0d/%0d flV=%b/%b flM=%h/%h inV=%b/%b inM=%h/%h exp=%b/%b deep=%b/%b (actual/expected)",
        curTag, enabledWays, mCnt, flushValid, mFlV, flushMask, mFlM, invValid, mInV,
        invMask, mInM, expandReq, mExp, deepAllowed, expDeep);
    end
  endtask

  task automatic tick();
    #1; compare(); modelStep(); @(negedge clk);
  endtask

  task automatic pulseSleep(logic [3:0] h);
    sleepHint = h; sleepEntry = 1; tick(); sleepEntry = 0; sleepHint = 0; tick();
  endtask
  task automatic pulseWake();
    wakeEvent = 1; tick(); wakeEvent = 0; tick();
  endtask
  task automatic pulseIrq();
    irqEvent = 1; tick(); irqEvent = 0; tick();
  endtask

  initial begin
    #400000;
    testsFailed++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    curTag = "R1"; tick(); tick();
    // R2 step shrink with saturation: 8 -> 5 -> 2 -> 0
    curTag = "R2"; pulseSleep(0); pulseSleep(0); pulseSleep(0); pulseSleep(0);
    // R13 deep allowed at zero, then dropped by prevent / disable
    curTag = "R13"; tick(); deepEnable = 0; tick(); deepEnable = 1; tick();
    curTag = "R7"; pulseWake();
    curTag = "R8"; pulseSleep(0);
    curTag = "R11"; shrinkPrevent = 1; tick(); pulseSleep(0); shrinkPrevent = 0; tick();
    // R3 each condition failing in turn
    curTag = "R3"; otherCoreC4 = 0; pulseSleep(0); otherCoreC4 = 1;
    deepEnable = 0; pulseSleep(0); deepEnable = 1; pulseSleep(0);
    // R4 ratio zero allowed, ratio equal blocks
    curTag = "R4"; busRatio = 0; pulseSleep(0); busRatio = 10; pulseSleep(0); busRatio = 5;
    curTag = "R10"; shrinkPrevent = 1; pulseSleep(0); shrinkPrevent = 0; pulseSleep(4'h2);
    // R5 high ratio: expand request, no shrink; then R9 irq restores full
    curTag = "R5"; pulseWake(); busRatio = 12; pulseSleep(0); busRatio = 5;
    curTag = "R9"; pulseIrq();
    // R6 timer expiry blocks shrink
    curTag = "R6"; timerLimit = 20; pulseWake(); repeat (30) tick(); pulseSleep(0);
    timerLimit = 1000; pulseSleep(0);
    curTag = "R9"; otherShallowReq = 1; tick(); otherShallowReq = 0; tick();
    pulseWake(); pulseIrq();
    // R12 held handshake, dropped events, priority
    curTag = "R12"; flushReady = 0; pulseSleep(0); pulseSleep(0); pulseWake();
    flushReady = 1; sleepEntry = 1; tick(); sleepEntry = 0; tick();
    sleepEntry = 1; irqEvent = 1; wakeEvent = 1; tick();
    sleepEntry = 0; irqEvent = 0; wakeEvent = 0; tick(); tick();
    // random phase
    curTag = "R12_random";
    for (int blk = 0; blk < 8; blk++) begin
      timerLimit = (blk % 2) ? 16'd30 : 16'd2000;
      shrinkStep = WW'($urandom_range(0, 4));
      for (int c = 0; c < 600; c++) begin
        sleepEntry = ($urandom_range(0, 9) == 0);
        wakeEvent  = ($urandom_range(0, 9) == 0);
        irqEvent   = ($urandom_range(0, 19) == 0);
        sleepHint  = ($urandom_range(0, 4) == 0) ? 4'h2 : 4'($urandom_range(0, 15));
        otherCoreC4 = ($urandom_range(0, 4) != 0);
        otherShallowReq = ($urandom_range(0, 19) == 0);
        deepEnable = ($urandom_range(0, 9) != 0);
        shrinkPrevent = ($urandom_range(0, 19) == 0);
        busRatio = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'($urandom_range(1, 14));
        flushReady = ($urandom_range(0, 4) < 3);
        invReady = ($urandom_range(0, 4) < 3);
        tick();
      end
    end
    sleepEntry = 0; wakeEvent = 0; irqEvent = 0; tick();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule